// File: doc/BRIEF.md
# ASCII Arithmetic Command Parser

This block reads typed command lines one byte at a time and turns each one into a single arithmetic job. Bytes arrive on a valid/ready stream, usually straight from the receive FIFO of a serial port. They are stored in a line buffer until a carriage return or a line feed arrives. The stored line is then scanned one character per cycle against a small grammar: an optionally signed decimal operand, an operator character, and a second optionally signed decimal operand. Spaces are allowed around any token.

A line that passes the scan is decoded into two 32-bit two's-complement words. The operator character selects one of four external arithmetic units: add, subtract, multiply or divide. The block sends that unit the first word and then the second word on a shared operand bus with one valid/ready pair per unit. It then waits for the unit's result and places that result on the output stream with status code 0. A line that fails the scan, or that has an operand outside the 32-bit signed range, produces status 1 and never reaches a unit. A line longer than the buffer produces status 2.

While a line is being scanned, computed or reported, the block holds its input ready low. Any bytes that follow stay in the upstream FIFO and are not lost.

Top module: `calc_cmd_parser`

## Requirements
- R1: After reset, in_ready is 1 and out_valid and every op_valid bit are 0.
- R2: Operator decoding and unit index: '+' selects unit 0 (add), '-' selects unit 1 (subtract), '*', 'x' and 'X' select unit 2 (multiply), and '/' selects unit 3 (divide). Only op_valid[unit] is raised. The first operand is transferred first and the second operand second. op_valid and op_data stay unchanged until op_ready is seen.
- R3: For a valid line, the word returned on res_data[32*unit +: 32] while res_valid[unit] and res_ready[unit] are both high is delivered on out_data with out_status 0.
- R4: Each operand may carry one leading '-' and is converted to a 32-bit two's-complement word. Any number of spaces may stand before, between or after tokens. A '-' that directly follows a digit of the first operand is the subtract operator.
- R5: A line that breaks the grammar produces one output with out_status 1 and no unit transfer. Examples are a doubled sign, a non-digit after the second operand, letters in place of digits, a missing operand, and a line of only spaces.
- R6: An operand whose value lies outside -2147483648 to 2147483647 makes the line invalid (status 1). Both range ends are accepted.
- R7: The buffer holds 32 characters, and a line of exactly 32 characters is evaluated. A 33rd character that is not CR or LF sets overflow. All bytes up to and including the next CR or LF are then discarded, and a single output with out_status 2 is issued when that terminator is accepted.
- R8: CR (0x0D) and LF (0x0A) both end a line. A terminator that arrives with the buffer empty produces no output and leaves in_ready high, so an LF right after a CR is not a second command.
- R9: From the cycle after a non-empty line's terminator is accepted until its output is taken, in_ready is 0. Later bytes are accepted in order afterwards.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_status and out_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts an input byte |
| in_byte | input | 8 | ASCII character |
| op_valid | output | 4 | Operand offered, one bit per arithmetic unit |
| op_ready | input | 4 | Unit takes the operand, one bit per unit |
| op_data | output | 32 | Operand word shared by all units |
| res_valid | input | 4 | Unit result present, one bit per unit |
| res_ready | output | 4 | Block takes the unit result, one bit per unit |
| res_data | input | 128 | Unit results, unit k in bits 32*k+31 down to 32*k |
| out_valid | output | 1 | Report present |
| out_ready | input | 1 | Downstream takes the report |
| out_status | output | 2 | 0 result, 1 invalid line, 2 buffer overflow |
| out_data | output | 32 | Result word, meaningful only with status 0 |

## Verification
Two functions can meet in one cycle: storing into the buffer and ending the line. When the buffer already holds 32 characters, the same byte slot decides whether the line is evaluated or marked as overflowing. The bench provokes this with directed lines of exactly 32 and exactly 33 characters, each padded with spaces after a valid command. The bench expects a correct result for the first and status 2 for the second. It then sends a terminator pair after an overflow and expects the trailing LF to stay silent, with the next command still decoding correctly.

// File: rtl/calc_pkg.sv
package calc_pkg;

  localparam int WORD_W  = 32;
  localparam int N_UNITS = 4;
  localparam int MAG_W   = 36;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [MAG_W-1:0]  mag_t;

  typedef enum logic [1:0] {
    STAT_RESULT   = 2'd0,
    STAT_INVALID  = 2'd1,
    STAT_OVERFLOW = 2'd2
  } stat_e;

  typedef enum logic [1:0] {
    UNIT_ADD = 2'd0,
    UNIT_SUB = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  typedef enum logic [2:0] {
    CT_COLLECT,
    CT_DRAIN,
    CT_SCAN,
    CT_SEND_A,
    CT_SEND_B,
    CT_WAIT,
    CT_REPORT
  } ctl_e;

  typedef enum logic [3:0] {
    PS_IDLE,
    PS_PRE1,
    PS_SIGN1,
    PS_NUM1,
    PS_POST1,
    PS_PRE2,
    PS_SIGN2,
    PS_NUM2,
    PS_POST2
  } ps_e;

  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_SP    = 8'h20;
  localparam logic [7:0] CH_MINUS = 8'h2D;

  // Largest magnitude any operand may reach (the negative range end).
  localparam mag_t MAG_LIMIT = mag_t'(64'h0000_0000_8000_0000);
  localparam mag_t MAG_SAT   = MAG_LIMIT + mag_t'(1);

  function automatic logic is_term(input logic [7:0] c);
    return (c == CH_CR) || (c == CH_LF);
  endfunction

  function automatic logic is_digit(input logic [7:0] c);
    return (c >= 8'h30) && (c <= 8'h39);
  endfunction

  function automatic logic is_operator(input logic [7:0] c);
    return (c == 8'h2B) || (c == CH_MINUS) || (c == 8'h2A) ||
           (c == 8'h78) || (c == 8'h58) || (c == 8'h2F);
  endfunction

  function automatic unit_e op_unit(input logic [7:0] c);
    unit_e u;
    case (c)
      8'h2B:               u = UNIT_ADD;
      CH_MINUS:            u = UNIT_SUB;
      8'h2A, 8'h78, 8'h58: u = UNIT_MUL;
      default:             u = UNIT_DIV;
    endcase
    return u;
  endfunction

  // One decimal digit appended; saturates just above the legal range.
  function automatic mag_t mag_step(input mag_t m, input logic [7:0] c);
    mag_t n;
    if (m > MAG_LIMIT) return MAG_SAT;
    n = m * mag_t'(10) + mag_t'(c[3:0]);
    if (n > MAG_LIMIT) return MAG_SAT;
    return n;
  endfunction

  function automatic logic mag_fits(input mag_t m, input logic neg);
    return neg ? (m <= MAG_LIMIT) : (m < MAG_LIMIT);
  endfunction

  function automatic word_t to_word(input mag_t m, input logic neg);
    mag_t s;
    s = neg ? (mag_t'(0) - m) : m;
    return word_t'(s);
  endfunction

endpackage

// File: rtl/cmd_line_buffer.sv
module cmd_line_buffer #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic [CNT_W-1:0] fill_count
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[fill_count[IDX_W-1:0]] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     fill_count <= '0;
    else if (clr)   fill_count <= '0;
    else if (wr_en) fill_count <= fill_count + CNT_W'(1);
  end

  assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/cmd_scanner.sv
module cmd_scanner import calc_pkg::*; #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] line_len,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [7:0]       rd_byte,
  output logic             done,
  output logic             ok,
  output unit_e            unit,
  output word_t            opnd_a,
  output word_t            opnd_b
);

  logic             busy;
  ps_e              ps, ps_n;
  logic [CNT_W-1:0] idx;
  mag_t             mag, mag_n;
  logic             neg, neg_n;
  logic             err_n, a_take, at_end, end_ok;
  unit_e            unit_n;
  logic [7:0]       c;

  assign c      = rd_byte;
  assign rd_idx = idx[IDX_W-1:0];
  assign at_end = (idx == line_len);
  assign end_ok = ((ps == PS_NUM2) || (ps == PS_POST2)) && mag_fits(mag, neg);

  always_comb begin
    ps_n   = ps;
    mag_n  = mag;
    neg_n  = neg;
    unit_n = unit;
    err_n  = 1'b0;
    a_take = 1'b0;
    case (ps)
      PS_PRE1, PS_PRE2: begin
        if (c == CH_SP) begin
          ps_n = ps;
        end else if (c == CH_MINUS) begin
          neg_n = 1'b1;
          ps_n  = (ps == PS_PRE1) ? PS_SIGN1 : PS_SIGN2;
        end else if (is_digit(c)) begin
          mag_n = mag_step('0, c);
          ps_n  = (ps == PS_PRE1) ? PS_NUM1 : PS_NUM2;
        end else begin
          err_n = 1'b1;
        end
      end
      PS_SIGN1, PS_SIGN2: begin
        if (is_digit(c)) begin
          mag_n = mag_step('0, c);
          ps_n  = (ps == PS_SIGN1) ? PS_NUM1 : PS_NUM2;
        end else begin
          err_n = 1'b1;
        end
      end
      PS_NUM1: begin
        if (is_digit(c)) begin
          mag_n = mag_step(mag, c);
        end else if (c == CH_SP) begin
          a_take = 1'b1;
          ps_n   = PS_POST1;
        end else if (is_operator(c)) begin
          a_take = 1'b1;
          unit_n = op_unit(c);
          mag_n  = '0;
          neg_n  = 1'b0;
          ps_n   = PS_PRE2;
        end else begin
          err_n = 1'b1;
        end
      end
      PS_POST1: begin
        if (is_operator(c)) begin
          unit_n = op_unit(c);
          mag_n  = '0;
          neg_n  = 1'b0;
          ps_n   = PS_PRE2;
        end else if (c != CH_SP) begin
          err_n = 1'b1;
        end
      end
      PS_NUM2: begin
        if (is_digit(c))       mag_n = mag_step(mag, c);
        else if (c == CH_SP)   ps_n  = PS_POST2;
        else                   err_n = 1'b1;
      end
      PS_POST2: begin
        if (c != CH_SP) err_n = 1'b1;
      end
      default: err_n = 1'b1;
    endcase
    if (a_take && !mag_fits(mag, neg)) err_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      ok     <= 1'b0;
      ps     <= PS_IDLE;
      idx    <= '0;
      mag    <= '0;
      neg    <= 1'b0;
      unit   <= UNIT_ADD;
      opnd_a <= '0;
      opnd_b <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        ps   <= PS_PRE1;
        idx  <= '0;
        mag  <= '0;
        neg  <= 1'b0;
      end else if (busy) begin
        if (at_end) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          ok     <= end_ok;
          opnd_b <= to_word(mag, neg);
          ps     <= PS_IDLE;
        end else if (err_n) begin
          busy <= 1'b0;
          done <= 1'b1;
          ok   <= 1'b0;
          ps   <= PS_IDLE;
        end else begin
          ps   <= ps_n;
          mag  <= mag_n;
          neg  <= neg_n;
          unit <= unit_n;
          idx  <= idx + CNT_W'(1);
          if (a_take) opnd_a <= to_word(mag, neg);
        end
      end
    end
  end

endmodule

// File: rtl/unit_port.sv
module unit_port #(
  parameter int N = 4,
  parameter int W = 32,
  localparam int SEL_W = $clog2(N)
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             send,
  input  logic             collect,
  input  logic [N-1:0]     op_ready,
  input  logic [N-1:0]     res_valid,
  input  logic [N*W-1:0]   res_data,
  output logic [N-1:0]     op_valid,
  output logic [N-1:0]     res_ready,
  output logic             sel_op_ready,
  output logic             sel_res_valid,
  output logic [W-1:0]     sel_res_data
);

  logic [W-1:0] slot [N];

  for (genvar k = 0; k < N; k++) begin : g_unit
    assign op_valid[k]  = send    && (sel == SEL_W'(k));
    assign res_ready[k] = collect && (sel == SEL_W'(k));
    assign slot[k]      = res_data[k*W +: W];
  end

  assign sel_op_ready  = op_ready[sel];
  assign sel_res_valid = res_valid[sel];
  assign sel_res_data  = slot[sel];

endmodule

// File: rtl/calc_cmd_parser.sv
module calc_cmd_parser import calc_pkg::*; #(
  parameter int LINE_DEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [7:0]                in_byte,
  output logic [N_UNITS-1:0]        op_valid,
  input  logic [N_UNITS-1:0]        op_ready,
  output logic [WORD_W-1:0]         op_data,
  input  logic [N_UNITS-1:0]        res_valid,
  output logic [N_UNITS-1:0]        res_ready,
  input  logic [N_UNITS*WORD_W-1:0] res_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [1:0]                out_status,
  output logic [WORD_W-1:0]         out_data
);

  localparam int CNT_W = $clog2(LINE_DEPTH + 1);
  localparam int IDX_W = $clog2(LINE_DEPTH);

  ctl_e             state;
  stat_e            stat_q;
  word_t            res_q;
  logic [CNT_W-1:0] fill_count;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_byte;
  logic             scan_done, scan_ok;
  unit_e            scan_unit;
  word_t            opnd_a, opnd_b;
  logic             sel_op_ready, sel_res_valid;
  word_t            sel_res_data;

  // Named internal events, also watched by the checker.
  logic byte_fire, byte_is_term, buf_full;
  logic store_evt, line_end_evt, ovf_evt, drain_end_evt, out_fire;
  logic sending, collecting;

  assign in_ready      = (state == CT_COLLECT) || (state == CT_DRAIN);
  assign byte_fire     = in_valid && in_ready;
  assign byte_is_term  = is_term(in_byte);
  assign buf_full      = (fill_count == CNT_W'(LINE_DEPTH));
  assign store_evt     = byte_fire && (state == CT_COLLECT) && !byte_is_term && !buf_full;
  assign ovf_evt       = byte_fire && (state == CT_COLLECT) && !byte_is_term && buf_full;
  assign line_end_evt  = byte_fire && (state == CT_COLLECT) && byte_is_term && (fill_count != '0);
  assign drain_end_evt = byte_fire && (state == CT_DRAIN) && byte_is_term;
  assign out_valid     = (state == CT_REPORT);
  assign out_fire      = out_valid && out_ready;
  assign sending       = (state == CT_SEND_A) || (state == CT_SEND_B);
  assign collecting    = (state == CT_WAIT);
  assign op_data       = (state == CT_SEND_A) ? opnd_a : opnd_b;
  assign out_status    = stat_q;
  assign out_data      = res_q;

  cmd_line_buffer #(.DEPTH(LINE_DEPTH)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (store_evt),
    .wr_byte    (in_byte),
    .clr        (out_fire),
    .rd_idx     (rd_idx),
    .rd_byte    (rd_byte),
    .fill_count (fill_count)
  );

  cmd_scanner #(.DEPTH(LINE_DEPTH)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (line_end_evt),
    .line_len (fill_count),
    .rd_idx   (rd_idx),
    .rd_byte  (rd_byte),
    .done     (scan_done),
    .ok       (scan_ok),
    .unit     (scan_unit),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b)
  );

  unit_port #(.N(N_UNITS), .W(WORD_W)) u_port (
    .sel           (scan_unit),
    .send          (sending),
    .collect       (collecting),
    .op_ready      (op_ready),
    .res_valid     (res_valid),
    .res_data      (res_data),
    .op_valid      (op_valid),
    .res_ready     (res_ready),
    .sel_op_ready  (sel_op_ready),
    .sel_res_valid (sel_res_valid),
    .sel_res_data  (sel_res_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= CT_COLLECT;
      stat_q <= STAT_RESULT;
      res_q  <= '0;
    end else begin
      case (state)
        CT_COLLECT: begin
          if (ovf_evt)           state <= CT_DRAIN;
          else if (line_end_evt) state <= CT_SCAN;
        end
        CT_DRAIN: begin
          if (drain_end_evt) begin
            stat_q <= STAT_OVERFLOW;
            state  <= CT_REPORT;
          end
        end
        CT_SCAN: begin
          if (scan_done) begin
            if (scan_ok) begin
              state <= CT_SEND_A;
            end else begin
              stat_q <= STAT_INVALID;
              state  <= CT_REPORT;
            end
          end
        end
        CT_SEND_A: if (sel_op_ready) state <= CT_SEND_B;
        CT_SEND_B: if (sel_op_ready) state <= CT_WAIT;
        CT_WAIT: begin
          if (sel_res_valid) begin
            res_q  <= sel_res_data;
            stat_q <= STAT_RESULT;
            state  <= CT_REPORT;
          end
        end
        CT_REPORT: if (out_ready) state <= CT_COLLECT;
        default:   state <= CT_COLLECT;
      endcase
    end
  end

endmodule

// File: rtl/calc_cmd_parser_chk.sv
module calc_cmd_parser_chk #(
  parameter int LINE_DEPTH = 32,
  localparam int CNT_W = $clog2(LINE_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_byte,
  input logic [3:0]       op_valid,
  input logic [3:0]       op_ready,
  input logic [31:0]      op_data,
  input logic [3:0]       res_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_status,
  input logic [31:0]      out_data,
  input logic [CNT_W-1:0] fill_count,
  input logic             store_evt
);

  logic term_in;
  assign term_in = (in_byte == 8'h0D) || (in_byte == 8'h0A);

  assert_in_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|op_valid) || (|res_ready) || out_valid) |-> !in_ready);

  assert_one_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_valid));

  assert_one_collect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_ready));

  assert_op_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|op_valid) && ((op_valid & op_ready) == 4'b0)) |=>
      ((op_valid == $past(op_valid)) && (op_data == $past(op_data))));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_status) && $stable(out_data)));

  assert_status_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_status != 2'd3));

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CNT_W'(LINE_DEPTH));

  assert_store_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> (fill_count == $past(fill_count) + CNT_W'(1)));

  assert_drain_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !term_in && (fill_count == CNT_W'(LINE_DEPTH))) |=>
      (in_ready && !out_valid));

  assert_empty_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && term_in && (fill_count == '0)) |=>
      (in_ready && !out_valid));

endmodule

bind calc_cmd_parser calc_cmd_parser_chk #(.LINE_DEPTH(LINE_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_byte    (in_byte),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .op_data    (op_data),
  .res_ready  (res_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_status (out_status),
  .out_data   (out_data),
  .fill_count (fill_count),
  .store_evt  (store_evt)
);

// File: tb/calc_cmd_parser_bench.sv
module calc_cmd_parser_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_byte = 8'h00;
  logic [3:0]   op_valid;
  logic [3:0]   op_ready = 4'h0;
  logic [31:0]  op_data;
  logic [3:0]   res_valid = 4'h0;
  logic [3:0]   res_ready;
  logic [127:0] res_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [1:0]   out_status;
  logic [31:0]  out_data;

  always #2 clk = ~clk;

  calc_cmd_parser u_calc_cmd_parser (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .op_valid(op_valid), .op_ready(op_ready), .op_data(op_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_status(out_status), .out_data(out_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Expected reports and expected unit jobs, in order.
  logic [1:0]  eq_stat [0:511];
  logic [31:0] eq_data [0:511];
  int          eq_wr = 0, eq_rd = 0;
  int          uq_unit [0:511];
  logic [31:0] uq_a [0:511];
  logic [31:0] uq_b [0:511];
  int          uq_wr = 0, uq_rd = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_calc(input int u, input logic [31:0] a, input logic [31:0] b);
    case (u)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      default: begin
        if (b == 32'h0) return 32'hFFFF_FFFF;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
        return $signed(a) / $signed(b);
      end
    endcase
  endfunction

  function automatic int unit_of(input byte c);
    if (c == "+") return 0;
    if (c == "-") return 1;
    if (c == "/") return 3;
    return 2;
  endfunction

  // Arithmetic unit model: takes two operands, answers after a short delay.
  initial begin
    int phase = 0, u = 0, dly = 0;
    logic drop = 1'b0;
    logic [31:0] a = '0, b = '0, r;
    forever begin
      @(negedge clk);
      if (drop) begin
        res_valid = 4'h0;
        drop = 1'b0;
        phase = 0;
      end
      op_ready = (($urandom % 4) != 0) ? 4'hF : 4'h0;
      if (phase < 2 && (|(op_valid & op_ready))) begin
        for (int k = 0; k < 4; k++) if (op_valid[k]) u = k;
        if (phase == 0) a = op_data; else b = op_data;
        phase++;
        if (phase == 2) begin
          if (uq_rd == uq_wr) begin
            n_tests++; n_fail++;
            $display("FAIL R5 unexpected unit job actual=unit%0d expected=none", u);
          end else begin
            check("R2 unit index", u, uq_unit[uq_rd]);
            check("R4 first operand", a, uq_a[uq_rd]);
            check("R4 second operand", b, uq_b[uq_rd]);
            uq_rd++;
          end
          dly = $urandom % 3;
        end
      end else if (phase == 2) begin
        if (dly == 0) begin
          r = ref_calc(u, a, b);
          res_data[u*32 +: 32] = r;
          res_valid = 4'h0;
          res_valid[u] = 1'b1;
          phase = 3;
        end else dly--;
      end
      if (phase == 3 && res_ready[u]) drop = 1'b1;
    end
  end

  // Output monitor with random backpressure.
  initial begin
    logic hold = 1'b0;
    logic [1:0] h_stat = '0;
    logic [31:0] h_data = '0;
    forever begin
      @(negedge clk);
      if (hold) begin
        check("R10 held valid", {31'b0, out_valid}, 32'h1);
        check("R10 held status", {30'b0, out_status}, {30'b0, h_stat});
        if (h_stat == 2'd0) check("R10 held data", out_data, h_data);
      end
      out_ready = (($urandom % 4) != 0);
      hold = out_valid && !out_ready;
      h_stat = out_status;
      h_data = out_data;
      if (out_valid && out_ready) begin
        if (eq_rd == eq_wr) begin
          n_tests++; n_fail++;
          $display("FAIL R8 unexpected report actual=status%0d expected=none", out_status);
        end else begin
          case (eq_stat[eq_rd])
            2'd0: begin
              check("R3 status", {30'b0, out_status}, 32'd0);
              check("R3 result", out_data, eq_data[eq_rd]);
            end
            2'd1:    check("R5/R6 invalid status", {30'b0, out_status}, 32'd1);
            default: check("R7 overflow status", {30'b0, out_status}, 32'd2);
          endcase
          eq_rd++;
        end
      end
    end
  end

  task automatic send_byte(input byte c);
    int gap = $urandom % 3;
    for (int i = 0; i < gap; i++) @(negedge clk);
    in_valid = 1'b1;
    in_byte  = c;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // kind: 0 no report, 1 result, 2 invalid, 3 overflow
  task automatic send_line(input string body, input byte term, input int kind,
                           input int u, input logic [31:0] a, input logic [31:0] b);
    if (kind == 1) begin
      uq_unit[uq_wr] = u; uq_a[uq_wr] = a; uq_b[uq_wr] = b; uq_wr++;
      eq_stat[eq_wr] = 2'd0; eq_data[eq_wr] = ref_calc(u, a, b); eq_wr++;
    end else if (kind == 2) begin
      eq_stat[eq_wr] = 2'd1; eq_data[eq_wr] = '0; eq_wr++;
    end else if (kind == 3) begin
      eq_stat[eq_wr] = 2'd2; eq_data[eq_wr] = '0; eq_wr++;
    end
    for (int i = 0; i < body.len(); i++) send_byte(body[i]);
    send_byte(term);
    if (body.len() > 0) check("R9 input held after line end", {31'b0, in_ready}, 32'h0);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000; i++) begin
      if (eq_rd == eq_wr && uq_rd == uq_wr && !out_valid) break;
      @(negedge clk);
    end
    check("R9 all reports delivered", eq_rd, eq_wr);
  endtask

  function automatic string spaces(input int n);
    string s = "";
    for (int i = 0; i < n; i++) s = {s, " "};
    return s;
  endfunction

  function automatic logic [31:0] pick_operand();
    case ($urandom % 4)
      0: return 32'($urandom % 100) - 32'd50;
      1: return $urandom;
      2: return ($urandom % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      default: return 32'($urandom % 100000);
    endcase
  endfunction

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    string ops = "+-*xX/";
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R1 in_ready in reset", {31'b0, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready", {31'b0, in_ready}, 32'h1);
    check("R1 out_valid", {31'b0, out_valid}, 32'h0);
    check("R1 op_valid", {28'b0, op_valid}, 32'h0);

    // Directed corner cases
    send_line("-6--4", 8'h0A, 1, 1, 32'hFFFF_FFFA, 32'hFFFF_FFFC);          // R4
    send_line(" 12 / 4 ", 8'h0D, 1, 3, 32'd12, 32'd4);                       // R4 R2
    send_line("7X6", 8'h0A, 1, 2, 32'd7, 32'd6);                             // R2
    send_line("9x3", 8'h0A, 1, 2, 32'd9, 32'd3);                             // R2
    send_line("4x--2", 8'h0A, 2, 0, 0, 0);                                   // R5
    send_line("-5+3a", 8'h0A, 2, 0, 0, 0);                                   // R5
    send_line("hello+world", 8'h0D, 2, 0, 0, 0);                             // R5
    send_line("3+", 8'h0A, 2, 0, 0, 0);                                      // R5
    send_line("   ", 8'h0A, 2, 0, 0, 0);                                     // R5
    send_line("2147483648+1", 8'h0A, 2, 0, 0, 0);                            // R6
    send_line("1+-2147483649", 8'h0A, 2, 0, 0, 0);                           // R6
    send_line("-2147483648-1", 8'h0A, 1, 1, 32'h8000_0000, 32'd1);           // R6
    send_line("2147483647*-2147483648", 8'h0A, 1, 2, 32'h7FFF_FFFF, 32'h8000_0000); // R6
    wait_drain();

    // R8: CR then LF gives one report; a lone terminator gives none
    send_line("7*6", 8'h0D, 1, 2, 32'd7, 32'd6);
    wait_drain();
    send_line("", 8'h0A, 0, 0, 0, 0);
    send_line("", 8'h0D, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    check("R8 no report for empty line", {31'b0, out_valid}, 32'h0);
    check("R8 still accepting", {31'b0, in_ready}, 32'h1);

    // R7: full buffer boundary
    send_line({"1+2", spaces(29)}, 8'h0A, 1, 0, 32'd1, 32'd2);
    send_line({"1+2", spaces(30)}, 8'h0A, 3, 0, 0, 0);
    send_line({"8/2", spaces(30), "garbage"}, 8'h0D, 3, 0, 0, 0);
    wait_drain();
    send_line("", 8'h0A, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    check("R7 no report for LF after overflow", {31'b0, out_valid}, 32'h0);
    send_line("5*5", 8'h0A, 1, 2, 32'd5, 32'd5);
    send_line("10/0", 8'h0A, 1, 3, 32'd10, 32'd0);
    wait_drain();

    // Random commands, back to back
    for (int n = 0; n < 150; n++) begin
      logic [31:0] a = pick_operand();
      logic [31:0] b = pick_operand();
      byte oc = ops[$urandom % 6];
      string s;
      s = {spaces($urandom % 2), $sformatf("%0d", $signed(a)), spaces($urandom % 2),
           $sformatf("%c", oc), spaces($urandom % 2), $sformatf("%0d", $signed(b)),
           spaces($urandom % 2)};
      send_line(s, ($urandom % 2) ? 8'h0A : 8'h0D, 1, unit_of(oc), a, b);
      if (n % 25 == 24) send_line("1+x", 8'h0A, 2, 0, 0, 0);
    end
    wait_drain();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule